// File: doc/BRIEF.md
# Wide-Mode UART Receiver Formatter

This block receives asynchronous serial characters from an RX line and hands them to a host through a byte-wide read port. The line is oversampled by a 16x enable pulse. Characters may be 7, 8 or 9 data bits long. Characters of 7 or 8 bits may carry an even or odd parity bit. Each finished character goes into a receive FIFO as a single entry. That entry holds the data and the error tags that belong to that character: parity error, framing error, break and overrun.

On the read side the block has two output formats. In normal mode each character yields one data byte, with no error information. In wide mode each character yields two bytes. The first is the data byte. The second is a status byte with the character's own error flags, or with its ninth data bit. Apart from the FIFO, a small set of sticky error flags records that some error occurred since the host last read them. These flags do not say which character was affected, and the host clears them with a read strobe. The baud-rate enable comes from outside the block.

Top module: `wide_uart_rx`

## Requirements
- R1: A character starts when the line reads low while idle. Every bit is sampled once per 16 `tick16` pulses, at the middle of the bit, and data bits arrive LSB first. If the start bit reads high at its middle, it is dropped as a glitch and nothing is stored.
- R2: In normal mode (`cfg_wide`=0) each character gives one byte, data bits 7:0. `cfg_len` selects the length: 0 for 7 bits, 1 for 8 bits, 2 or 3 for 9 bits. Bit 7 of the byte is 0 for 7-bit characters. For 9-bit characters the ninth bit is discarded. No error information appears in this mode.
- R3: In wide mode each character gives two bytes, the data byte first and then a status byte. The status byte holds bit0 = parity error or ninth bit, bit1 = break, bit2 = framing error and bit3 = overrun. Bits 7:4 of the status byte are 0.
- R4: Parity follows the data bits only for 7- and 8-bit characters with `cfg_par_en`=1. It is even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. Status bit0 is the parity error for those characters, and it is 0 when parity is disabled. For 9-bit characters no parity bit is expected and bit0 carries data bit 8.
- R5: A stop bit that reads low sets the framing flag for that character. The receiver then waits for the line to go high before it looks for the next start bit.
- R6: A break is flagged when the data bits, the parity bit (if one is used) and the stop bit all read low. The break also sets the framing flag. A break held low for any length stores exactly one entry.
- R7: The FIFO holds DEPTH characters. A character that completes while the FIFO is full is lost. The next character that is stored carries the overrun flag, and later characters do not.
- R8: The sticky flags are `sts[0]` parity, `sts[1]` break, `sts[2]` framing and `sts[3]` overrun. Each flag is set when its error happens and stays set until a `sts_rd` pulse clears it. A new error arriving in the same cycle as `sts_rd` wins.
- R9: `rd_valid` is high while a character is buffered. A `rd_en` pulse steps to the next byte. A `rd_en` while `rd_valid` is low has no effect.
- R10: After reset `rd_valid` is 0 and `sts` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| rx | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Character length: 0 = 7 bits, 1 = 8 bits, 2/3 = 9 bits |
| cfg_par_en | input | 1 | Parity bit present (7/8-bit characters) |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_wide | input | 1 | Two-byte output with status byte |
| rd_en | input | 1 | Host read strobe, steps to the next output byte |
| rd_valid | output | 1 | An output byte is available |
| rd_data | output | 8 | Current output byte |
| sts_rd | input | 1 | Clears the sticky error flags |
| sts | output | 4 | Sticky flags {overrun, framing, break, parity} |

## Verification
The assertions assume that the configuration inputs change only while the receiver is idle and the FIFO is empty. They also assume that `sts_rd` and `rd_en` are single-cycle strobes. The bench keeps to this by changing `cfg_len`, `cfg_par_en`, `cfg_par_odd` and `cfg_wide` only after every buffered byte has been read and the line has been idle for some time. The bench drives `tick16` high on every cycle, so one bit lasts 16 clocks. It holds each bit level for exactly that long, and any low stop bit or break is held until a high line returns.

// File: rtl/wide_uart_rx.sv
module wide_uart_rx #(
  parameter int DEPTH = 384,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_wide,
  input  logic       rd_en,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       sts_rd,
  output logic [3:0] sts
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] MID  = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITH} st_t;

  st_t           st;
  logic [1:0]    rx_sq;
  logic [PW-1:0] ph;
  logic [3:0]    idx;
  logic [8:0]    dat;
  logic          pbit, lost, half;
  logic [11:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire       rx_s     = rx_sq[1];
  wire       nine     = cfg_len[1];
  wire       use_par  = cfg_par_en && !nine;
  wire [3:0] last_idx = nine ? 4'd8 : (cfg_len[0] ? 4'd7 : 4'd6);

  wire store = tick16 && st == S_STOP && ph == LAST;
  wire frm   = !rx_s;
  wire brk   = frm && dat == 9'd0 && !(use_par && pbit);
  wire perr  = use_par && (^dat[7:0] ^ pbit ^ cfg_par_odd);
  wire b0    = nine ? dat[8] : perr;

  wire full  = cnt == CW'(DEPTH);
  wire push  = store && !full;
  wire drop  = store && full;
  wire step  = rd_en && rd_valid;
  wire pop   = step && (!cfg_wide || half);

  wire [11:0] head = mem[rp];
  assign rd_valid = cnt != '0;
  assign rd_data  = (cfg_wide && half) ? {4'b0000, head[11:8]} : head[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sq <= 2'b11;
    else        rx_sq <= {rx_sq[0], rx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; idx <= '0; dat <= '0; pbit <= 1'b0;
    end else if (tick16) begin
      case (st)
        S_IDLE: if (!rx_s) begin st <= S_START; ph <= '0; end
        S_START:
          if (ph == MID) begin
            ph <= '0;
            if (rx_s) st <= S_IDLE;
            else begin st <= S_DATA; idx <= '0; dat <= '0; pbit <= 1'b0; end
          end else ph <= ph + 1'b1;
        S_WAITH: if (rx_s) st <= S_IDLE;
        default: begin
          ph <= (ph == LAST) ? '0 : ph + 1'b1;
          if (ph == LAST) begin
            case (st)
              S_DATA: begin
                dat[idx] <= rx_s;
                idx <= idx + 1'b1;
                if (idx == last_idx) st <= use_par ? S_PAR : S_STOP;
              end
              S_PAR:   begin pbit <= rx_s; st <= S_STOP; end
              default: st <= rx_s ? S_IDLE : S_WAITH;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {lost, frm, brk, b0, dat[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; lost <= 1'b0; half <= 1'b0; sts <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (drop) lost <= 1'b1;
      else if (push) lost <= 1'b0;
      if (!cfg_wide) half <= 1'b0;
      else if (step) half <= !half;
      sts <= (sts_rd ? 4'b0000 : sts) | {drop, store && frm, store && brk, store && perr};
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_lost_char_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !pop |=> cnt == $past(cnt));
  assert_empty_read_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_valid && !store |=> !rd_valid && half == $past(half));
  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd && !store |=> sts == 4'b0000);
  assert_glitch_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 && st == S_START && ph == MID && rx_s |=> !store && st == S_IDLE);
  assert_seven_bit_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !half && cfg_len == 2'd0 |-> !rd_data[7]);
  assert_status_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && half |-> rd_data[7:4] == 4'b0000);
endmodule

// File: tb/wide_uart_rx_bench.sv
module wide_uart_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [1:0] cfg_len = 2'd1;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_wide = 1'b0;
  logic rd_en = 1'b0, sts_rd = 1'b0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic [3:0] sts;
  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wide_uart_rx #(.DEPTH(4), .OVS(16)) u_wide_uart_rx (
    .clk(clk), .rst_n(rst_n), .tick16(1'b1), .rx(rx),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_wide(cfg_wide), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .sts_rd(sts_rd), .sts(sts));

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(bit b, int n);
    rx = b;
    repeat (n) @(negedge clk);
  endtask

  // pmode: 0 no parity bit, 1 correct parity, 2 wrong parity
  task automatic send(int n, int val, int pmode, bit stop);
    bit p;
    p = cfg_par_odd;
    hold(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      hold(val[i], 16);
      p ^= val[i];
    end
    if (pmode == 1) hold(p, 16);
    if (pmode == 2) hold(!p, 16);
    hold(stop, 16);
    hold(1'b1, 20);
  endtask

  task automatic rd(string req, int exp);
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_sts();
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
    chk("R8", sts, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", rd_valid, 0);
    chk("R10", sts, 0);

    // R2: 8-bit normal sweep
    cfg_len = 2'd1;
    for (int v = 0; v < 256; v++) begin
      send(8, v, 0, 1'b1);
      rd("R2", v);
    end
    chk("R9", rd_valid, 0);

    // R2: 7-bit normal sweep, bit 7 reads 0
    cfg_len = 2'd0;
    for (int v = 0; v < 128; v++) begin
      send(7, v, 0, 1'b1);
      rd("R2", v);
    end

    // R2: 9-bit normal, ninth bit dropped
    cfg_len = 2'd2;
    for (int v = 0; v < 16; v++) begin
      send(9, 256 + v * 13, 0, 1'b1);
      rd("R2", (v * 13) & 255);
      chk("R2", rd_valid, 0);
    end

    // R3 R4: wide 9-bit, parity enable ignored, bit0 = ninth bit
    cfg_wide = 1'b1; cfg_par_en = 1'b1; cfg_len = 2'd3;
    for (int v = 0; v < 32; v++) begin
      int w;
      w = (v * 37 + v / 3) & 511;
      send(9, w, 0, 1'b1);
      rd("R3", w & 255);
      rd("R4", w >> 8);
    end
    chk("R8", sts, 0);

    // R4: parity, 8 and 7 bits, even and odd, good and bad
    for (int m = 0; m < 4; m++) begin
      cfg_len = (m < 2) ? 2'd1 : 2'd0;
      cfg_par_odd = m[0];
      for (int v = 0; v < 24; v++) begin
        int w;
        int bad;
        w = (v * 29 + m * 7) & ((m < 2) ? 255 : 127);
        bad = v % 3 == 0 ? 1 : 0;
        send((m < 2) ? 8 : 7, w, bad ? 2 : 1, 1'b1);
        rd("R4", w);
        rd("R4", bad);
      end
    end
    chk("R8", sts, 1);
    clear_sts();

    // R4: parity disabled gives bit0 = 0
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_len = 2'd1;
    send(8, 8'h81, 0, 1'b1);
    rd("R4", 8'h81);
    rd("R4", 0);

    // R5: framing error
    send(8, 8'h5A, 0, 1'b0);
    rd("R5", 8'h5A);
    rd("R5", 8'h04);
    chk("R5", rd_valid, 0);
    chk("R8", sts, 4'b0100);
    clear_sts();

    // R6: long break gives one entry
    hold(1'b0, 16 * 10 + 60);
    hold(1'b1, 30);
    rd("R6", 0);
    rd("R6", 8'h06);
    chk("R6", rd_valid, 0);
    chk("R8", sts, 4'b0110);
    clear_sts();

    // R1: short low pulse is a glitch
    hold(1'b0, 4);
    hold(1'b1, 60);
    chk("R1", rd_valid, 0);

    // R9: read strobe while empty has no effect
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    send(8, 8'h33, 0, 1'b1);
    rd("R9", 8'h33);
    rd("R9", 0);
    chk("R9", rd_valid, 0);

    // R7: overrun tagging
    for (int v = 0; v < 5; v++) send(8, 16 + v, 0, 1'b1);
    chk("R8", sts, 4'b1000);
    for (int v = 0; v < 4; v++) begin
      rd("R7", 16 + v);
      rd("R7", 0);
    end
    chk("R7", rd_valid, 0);
    send(8, 8'h15, 0, 1'b1);
    send(8, 8'h16, 0, 1'b1);
    rd("R7", 8'h15);
    rd("R7", 8'h08);
    rd("R7", 8'h16);
    rd("R7", 0);
    clear_sts();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule